// File: doc/BRIEF.md
# SCSI Controller Command Dispatcher

This block sits behind the command register of a SCSI protocol controller. The host writes one command byte at a time. The most significant bit asks for the operation to run with DMA. The remaining seven bits are the opcode. The dispatcher sorts the opcode into one of four groups and checks it against the controller's present connection state. These inputs describe that state: whether the controller is connected as initiator, and the current bus phase. A legal command leaves the block as a one-cycle start pulse with its opcode and DMA flag. An illegal command never starts; it sets a dedicated cause bit in the interrupt register instead.

The block also holds the interrupt-cause register. The bus engine sets cause bits in it through an event vector. The host clears the whole register with a read strobe. The register drives the interrupt line. A status byte combines the bus phase, the transfer flags and the pending interrupt. Bus signalling, FIFO traffic and the DMA engine are outside the block.

Top module: `scsi_cmd_dispatch`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `op_start` is 0, `int_reg` is 0x00 and `irq` is 0.
- R2: Opcodes 0x00 to 0x03 (no-op, FIFO flush, chip reset, bus reset) are accepted in every state. The cycle after the write, `op_start` is 1 and `op_code` equals the written opcode.
- R3: Accepting opcode 0x03 sets `int_reg` bit 7 the cycle after the write, but only when `rst_rpt_dis` is 0. The other control opcodes set no cause bit.
- R4: Opcodes 0x10 to 0x1b are accepted only when `connected` is 1.
- R5: Opcodes 0x20 to 0x2b are accepted only when `connected` is 1 and `bus_phase` is 110 (message out) or 111 (message in).
- R6: Opcodes 0x40 to 0x47 are accepted only when `connected` is 0.
- R7: A write is rejected when its opcode is outside those ranges, or is in a range whose condition fails. A rejected write produces no `op_start` and sets `int_reg` bit 6 (illegal command) the cycle after the write.
- R8: `op_dma` carries bit 7 of the accepted command byte, in the same cycle as its `op_start` pulse.
- R9: Each bit of `ev_set` except bit 6 sets the matching `int_reg` bit the next cycle. Bit 6 of `ev_set` has no effect. Set bits stay set until a read.
- R10: An `int_rd` strobe clears `int_reg` and `irq` the next cycle. A cause that is set in the same cycle as the read survives the clear.
- R11: `status` is {irq, 0, parity_err, tc_zero, xfer_done, bus_phase[2:0]} from bit 7 down to bit 0. The phase codes are: data out 000, data in 001, command 010, status 011, message out 110, message in 111. `irq` is 1 exactly when any `int_reg` bit is set.
- R12: Each accepted write gives exactly one `op_start` cycle. Back-to-back writes give back-to-back pulses, each with its own opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command: bit 7 DMA mode, bits 6:0 opcode |
| connected | input | 1 | Controller connected to a target as initiator |
| bus_phase | input | 3 | Current bus phase {MSG, C/D, I/O} |
| rst_rpt_dis | input | 1 | Suppress the bus-reset cause bit |
| ev_set | input | 8 | Cause bits raised by the bus engine |
| int_rd | input | 1 | Interrupt register read strobe (clears it) |
| xfer_done | input | 1 | Transfer complete flag |
| tc_zero | input | 1 | Transfer counter is zero |
| parity_err | input | 1 | Parity error flag |
| op_start | output | 1 | One-cycle start pulse for an accepted command |
| op_code | output | 7 | Opcode of the accepted command |
| op_dma | output | 1 | DMA mode of the accepted command |
| int_reg | output | 8 | Interrupt cause register |
| irq | output | 1 | Interrupt line |
| status | output | 8 | Status byte |

## Verification
A wrong group decode or a wrong state qualifier shows one cycle after the write, in two places. A start pulse appears where `int_reg` bit 6 should rise, or the reverse. The sweep over every command byte, both connection states, all eight phases and both reset-report settings exposes this quickly. A cause bit that sticks or drops shows on `irq` and on status bit 7. Such a fault is seen no later than the cycle after the next read strobe, because every read is expected to leave the register at zero.

// File: rtl/scsi_cmd_dispatch_pkg.sv
package scsi_cmd_dispatch_pkg;

   typedef enum logic [2:0] {
      GRP_CTRL = 3'd0,
      GRP_INIT = 3'd1,
      GRP_MSG  = 3'd2,
      GRP_SEL  = 3'd3,
      GRP_NONE = 3'd4
   } cmd_grp_e;

   // message phases are the two codes with MSG and C/D both high
   function automatic logic is_msg_phase(input logic [2:0] ph);
      return ph[2] & ph[1];
   endfunction

endpackage

// File: rtl/sdc_opcode_classify.sv
module sdc_opcode_classify
   import scsi_cmd_dispatch_pkg::*;
#(
   parameter int OP_W  = 7,
   parameter int G1_HI = 3,
   parameter int G2_LO = 16,
   parameter int G2_HI = 27,
   parameter int G3_LO = 32,
   parameter int G3_HI = 43,
   parameter int G4_LO = 64,
   parameter int G4_HI = 71
) (
   input  logic [OP_W-1:0] op,
   input  logic            connected,
   input  logic            in_msg,
   output logic            legal
);

   localparam int NRANGE = 3;
   localparam int LO [NRANGE] = '{G2_LO, G3_LO, G4_LO};
   localparam int HI [NRANGE] = '{G2_HI, G3_HI, G4_HI};

   logic [NRANGE-1:0] hit;
   cmd_grp_e          grp;

   genvar g;
   generate
      for (g = 0; g < NRANGE; g++) begin : g_range
         assign hit[g] = (op >= OP_W'(LO[g])) && (op <= OP_W'(HI[g]));
      end
   endgenerate

   always_comb begin
      if (op <= OP_W'(G1_HI))   grp = GRP_CTRL;
      else if (hit[0])          grp = GRP_INIT;
      else if (hit[1])          grp = GRP_MSG;
      else if (hit[2])          grp = GRP_SEL;
      else                      grp = GRP_NONE;
   end

   always_comb begin
      unique case (grp)
         GRP_CTRL: legal = 1'b1;
         GRP_INIT: legal = connected;
         GRP_MSG:  legal = connected & in_msg;
         GRP_SEL:  legal = ~connected;
         default:  legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/sdc_int_cause.sv
module sdc_int_cause #(
   parameter int INT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INT_W-1:0] set_vec,
   input  logic             clr,
   output logic [INT_W-1:0] q
);

   genvar b;
   generate
      for (b = 0; b < INT_W; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          q[b] <= 1'b0;
            else if (set_vec[b]) q[b] <= 1'b1;
            else if (clr)        q[b] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/sdc_phase_status.sv
module sdc_phase_status (
   input  logic [2:0] phase,
   input  logic       xfer_done,
   input  logic       tc_zero,
   input  logic       parity_err,
   input  logic       pending,
   output logic [7:0] stat
);

   always_comb begin
      stat      = '0;
      stat[2:0] = phase;
      stat[3]   = xfer_done;
      stat[4]   = tc_zero;
      stat[5]   = parity_err;
      stat[7]   = pending;
   end

endmodule

// File: rtl/scsi_cmd_dispatch.sv
module scsi_cmd_dispatch
   import scsi_cmd_dispatch_pkg::*;
#(
   parameter int CMD_W      = 8,
   parameter int INT_W      = 8,
   parameter int G1_HI      = 3,
   parameter int G2_LO      = 16,
   parameter int G2_HI      = 27,
   parameter int G3_LO      = 32,
   parameter int G3_HI      = 43,
   parameter int G4_LO      = 64,
   parameter int G4_HI      = 71,
   parameter int BUSRST_OP  = 3,
   parameter int ILL_BIT    = 6,
   parameter int BRST_BIT   = 7,
   parameter bit STATUS_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_byte,
   input  logic             connected,
   input  logic [2:0]       bus_phase,
   input  logic             rst_rpt_dis,
   input  logic [INT_W-1:0] ev_set,
   input  logic             int_rd,
   input  logic             xfer_done,
   input  logic             tc_zero,
   input  logic             parity_err,
   output logic             op_start,
   output logic [CMD_W-2:0] op_code,
   output logic             op_dma,
   output logic [INT_W-1:0] int_reg,
   output logic             irq,
   output logic [7:0]       status
);

   localparam int OP_W = CMD_W - 1;
   localparam logic [INT_W-1:0] ILL_MASK  = INT_W'(1) << ILL_BIT;
   localparam logic [INT_W-1:0] BRST_MASK = INT_W'(1) << BRST_BIT;

   // elaboration-time parameter checks
   generate
      if (CMD_W < 8) begin : g_bad_cmd_w
         $error("CMD_W must be at least 8");
      end
      if (ILL_BIT >= INT_W || BRST_BIT >= INT_W || ILL_BIT == BRST_BIT) begin : g_bad_bits
         $error("cause bit positions out of range or overlapping");
      end
      if (!(G1_HI < G2_LO && G2_LO <= G2_HI && G2_HI < G3_LO && G3_LO <= G3_HI &&
            G3_HI < G4_LO && G4_LO <= G4_HI && G4_HI < (1 << OP_W))) begin : g_bad_ranges
         $error("opcode group ranges must be ordered and fit the opcode field");
      end
      if (BUSRST_OP > G1_HI) begin : g_bad_busrst
         $error("bus reset opcode must lie in the control group");
      end
   endgenerate

   logic [OP_W-1:0]  op;
   logic             dma;
   logic             legal;
   logic             accept;
   logic             reject;
   logic             brst_rpt;
   logic [INT_W-1:0] set_vec;
   logic [7:0]       stat_c;

   assign op  = cmd_byte[OP_W-1:0];
   assign dma = cmd_byte[CMD_W-1];

   sdc_opcode_classify #(
      .OP_W (OP_W),
      .G1_HI(G1_HI), .G2_LO(G2_LO), .G2_HI(G2_HI),
      .G3_LO(G3_LO), .G3_HI(G3_HI), .G4_LO(G4_LO), .G4_HI(G4_HI)
   ) u_classify (
      .op       (op),
      .connected(connected),
      .in_msg   (is_msg_phase(bus_phase)),
      .legal    (legal)
   );

   assign accept   = cmd_wr & legal;
   assign reject   = cmd_wr & ~legal;
   assign brst_rpt = accept & (op == OP_W'(BUSRST_OP)) & ~rst_rpt_dis;

   always_comb begin
      set_vec = ev_set & ~ILL_MASK;
      if (reject)   set_vec = set_vec | ILL_MASK;
      if (brst_rpt) set_vec = set_vec | BRST_MASK;
   end

   sdc_int_cause #(.INT_W(INT_W)) u_cause (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(set_vec),
      .clr    (int_rd),
      .q      (int_reg)
   );

   assign irq = |int_reg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_start <= 1'b0;
         op_code  <= '0;
         op_dma   <= 1'b0;
      end else begin
         op_start <= accept;
         if (accept) begin
            op_code <= op;
            op_dma  <= dma;
         end
      end
   end

   sdc_phase_status u_status (
      .phase     (bus_phase),
      .xfer_done (xfer_done),
      .tc_zero   (tc_zero),
      .parity_err(parity_err),
      .pending   (irq),
      .stat      (stat_c)
   );

   generate
      if (STATUS_REG) begin : g_stat_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status <= '0;
            else        status <= stat_c;
         end
      end else begin : g_stat_comb
         assign status = stat_c;
      end
   endgenerate

endmodule

// File: rtl/scsi_cmd_dispatch_chk.sv
module scsi_cmd_dispatch_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_wr,
   input logic [7:0] cmd_byte,
   input logic       connected,
   input logic       rst_rpt_dis,
   input logic [7:0] ev_set,
   input logic       int_rd,
   input logic       op_start,
   input logic       op_dma,
   input logic [7:0] int_reg,
   input logic       irq
);

   p_start_needs_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |-> $past(cmd_wr));

   p_dma_follows_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |-> (op_dma == $past(cmd_byte[7])));

   p_select_when_connected_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_byte[6:3] == 4'b1000 && connected) |=> (!op_start && int_reg[6]));

   p_busrst_report_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_byte[6:0] == 7'h03 && !rst_rpt_dis) |=> int_reg[7]);

   p_cause_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !int_rd |=> ((~int_reg & $past(int_reg)) == 8'h00));

   p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (int_rd && ev_set == 8'h00 && !cmd_wr) |=> (int_reg == 8'h00 && !irq));

endmodule

bind scsi_cmd_dispatch scsi_cmd_dispatch_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_wr     (cmd_wr),
   .cmd_byte   (cmd_byte),
   .connected  (connected),
   .rst_rpt_dis(rst_rpt_dis),
   .ev_set     (ev_set),
   .int_rd     (int_rd),
   .op_start   (op_start),
   .op_dma     (op_dma),
   .int_reg    (int_reg),
   .irq        (irq)
);

// File: tb/scsi_cmd_dispatch_tb_top.sv
module scsi_cmd_dispatch_tb_top;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wr = 1'b0;
   logic [7:0] cmd_byte = '0;
   logic       connected = 1'b0;
   logic [2:0] bus_phase = '0;
   logic       rst_rpt_dis = 1'b0;
   logic [7:0] ev_set = '0;
   logic       int_rd = 1'b0;
   logic       xfer_done = 1'b0;
   logic       tc_zero = 1'b0;
   logic       parity_err = 1'b0;
   logic       op_start;
   logic [6:0] op_code;
   logic       op_dma;
   logic [7:0] int_reg;
   logic       irq;
   logic [7:0] status;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_P/2) clk = ~clk;

   scsi_cmd_dispatch dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
      .connected(connected), .bus_phase(bus_phase), .rst_rpt_dis(rst_rpt_dis),
      .ev_set(ev_set), .int_rd(int_rd), .xfer_done(xfer_done), .tc_zero(tc_zero),
      .parity_err(parity_err), .op_start(op_start), .op_code(op_code),
      .op_dma(op_dma), .int_reg(int_reg), .irq(irq), .status(status)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit exp_legal(input logic [6:0] op, input bit conn,
                                    input logic [2:0] ph);
      if (op <= 7'd3)                  return 1'b1;
      if (op >= 7'h10 && op <= 7'h1b)  return conn;
      if (op >= 7'h20 && op <= 7'h2b)  return conn && ph[2] && ph[1];
      if (op >= 7'h40 && op <= 7'h47)  return !conn;
      return 1'b0;
   endfunction

   function automatic string grp_tag(input logic [6:0] op);
      if (op <= 7'd3)                  return "R2";
      if (op >= 7'h10 && op <= 7'h1b)  return "R4";
      if (op >= 7'h20 && op <= 7'h2b)  return "R5";
      if (op >= 7'h40 && op <= 7'h47)  return "R6";
      return "R7";
   endfunction

   initial begin
      #(CLK_P * 200000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(op_start == 1'b0 && int_reg == 8'h00 && irq == 1'b0, "R1",
          {23'd0, op_start, int_reg}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(op_start == 1'b0 && int_reg == 8'h00 && irq == 1'b0, "R1",
          {23'd0, op_start, int_reg}, 32'h0);

      // sweep every command byte against every state
      for (int c = 0; c < 256; c++) begin
         for (int cn = 0; cn < 2; cn++) begin
            for (int ph = 0; ph < 8; ph++) begin
               for (int d = 0; d < 2; d++) begin
                  logic [6:0] op;
                  bit         lg;
                  logic [7:0] ei;
                  string      itag;
                  op = c[6:0];
                  lg = exp_legal(op, cn[0], ph[2:0]);
                  ei = lg ? 8'h00 : 8'h40;
                  if (lg && op == 7'd3 && d == 0) ei = 8'h80;
                  itag = (op == 7'd3) ? "R3" : (lg ? grp_tag(op) : "R7");
                  cmd_wr = 1'b1;
                  cmd_byte = c[7:0];
                  connected = cn[0];
                  bus_phase = ph[2:0];
                  rst_rpt_dis = d[0];
                  @(negedge clk);
                  cmd_wr = 1'b0;
                  chk(op_start == lg, lg ? grp_tag(op) : "R7",
                      {31'd0, op_start}, {31'd0, lg});
                  if (lg) begin
                     chk(op_code == op, grp_tag(op), {25'd0, op_code}, {25'd0, op});
                     chk(op_dma == c[7], "R8", {31'd0, op_dma}, {31'd0, c[7]});
                  end
                  chk(int_reg == ei, itag, {24'd0, int_reg}, {24'd0, ei});
                  int_rd = 1'b1;
                  @(negedge clk);
                  int_rd = 1'b0;
                  chk(int_reg == 8'h00 && irq == 1'b0, "R10",
                      {23'd0, irq, int_reg}, 32'h0);
                  chk(op_start == 1'b0, "R12", {31'd0, op_start}, 32'h0);
               end
            end
         end
      end

      // R12: back-to-back writes
      connected = 1'b0;
      cmd_wr = 1'b1;
      cmd_byte = 8'h81;
      @(negedge clk);
      cmd_byte = 8'h40;
      chk(op_start && op_code == 7'h01 && op_dma, "R12",
          {23'd0, op_start, op_dma, op_code}, {23'd0, 2'b11, 7'h01});
      @(negedge clk);
      cmd_wr = 1'b0;
      chk(op_start && op_code == 7'h40 && !op_dma, "R12",
          {23'd0, op_start, op_dma, op_code}, {23'd0, 2'b10, 7'h40});
      @(negedge clk);
      chk(op_start == 1'b0, "R12", {31'd0, op_start}, 32'h0);

      // R9: event bits, bit 6 ignored, sticky
      ev_set = 8'hFF;
      @(negedge clk);
      ev_set = 8'h00;
      chk(int_reg == 8'hBF, "R9", {24'd0, int_reg}, 32'hBF);
      chk(irq == 1'b1, "R11", {31'd0, irq}, 32'h1);
      repeat (3) @(negedge clk);
      chk(int_reg == 8'hBF, "R9", {24'd0, int_reg}, 32'hBF);
      chk(status[7] == 1'b1, "R11", {24'd0, status}, 32'h80);

      // R10: set during read survives
      int_rd = 1'b1;
      ev_set = 8'h08;
      @(negedge clk);
      int_rd = 1'b0;
      ev_set = 8'h00;
      chk(int_reg == 8'h08, "R10", {24'd0, int_reg}, 32'h08);
      int_rd = 1'b1;
      @(negedge clk);
      int_rd = 1'b0;
      chk(int_reg == 8'h00 && irq == 1'b0, "R10", {23'd0, irq, int_reg}, 32'h0);

      // R11: status layout across phases and flags
      for (int ph = 0; ph < 8; ph++) begin
         for (int f = 0; f < 8; f++) begin
            logic [7:0] es;
            bus_phase = ph[2:0];
            xfer_done = f[0];
            tc_zero = f[1];
            parity_err = f[2];
            es = {2'b00, f[2], f[1], f[0], ph[2:0]};
            #1;
            chk(status == es, "R11", {24'd0, status}, {24'd0, es});
            @(negedge clk);
         end
      end

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule